// File: doc/BRIEF.md
# Per-Token Symmetric INT8 Activation Quantizer

This block turns one token's activation vector, arriving as a stream of signed two's-complement fixed-point words, into a vector of signed 8-bit codes plus a per-token scale. It stores the whole token in a local buffer while tracking the largest magnitude. Once the token is complete it computes a reciprocal of that magnitude once. It then reads the buffer back and maps each element so that the largest magnitude lands on 127. Rounding is half away from zero and the result is clipped to the symmetric range, so -128 never appears.

The scale handed out is the token's own largest magnitude. A downstream dequantizer multiplies each code by scale/127. Because there is no zero point, zero stays zero. A token is closed either by a marker on its final input word or, failing that, when the buffer is full. Both streams use valid/ready handshakes. The block takes in the next token while the final output word of the previous one is still waiting to be consumed.

Top module: `qz_token_quant`

## Requirements
- R1: On the first output word of each token, `out_scale` equals the largest absolute value over that token's inputs, taken as an unsigned DATA_W-bit number, so an input of -2^(DATA_W-1) gives 2^(DATA_W-1).
- R2: For a token with nonzero scale m, each output code equals sign(x)·floor((254·|x| + m) / (2·m)). This is x·127/m rounded to nearest with ties away from zero, for example m=2, x=±1 gives ±64.
- R3: Every output code lies in -127..+127 (the 8-bit value 0x80 is never produced), and an element whose magnitude equals the token's scale gives exactly ±127.
- R4: An input element of zero produces an output code of zero.
- R5: A token whose elements are all zero produces all-zero codes and a scale of zero.
- R6: The scale and codes of a token depend only on that token, even directly after a token with a much larger magnitude.
- R7: Each token yields exactly as many output words as it had input words, in input order. `out_first` is 1 on the first word only and `out_last` is 1 on the final word only, and both are 1 on a one-word token.
- R8: An input word with `in_last`=1, or the MAX_LEN-th word of a token, closes the token. With the default MAX_LEN of 1024, a 1024-word run without a marker forms one token.
- R9: While `out_valid` is 1 and `out_ready` is 0, all output fields hold their values into the next cycle.
- R10: `in_ready` is 1 after reset. It is 0 from the cycle after a token is closed until that token's final output word has been loaded into the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts an input word |
| in_data | input | DATA_W | Signed two's-complement activation element |
| in_last | input | 1 | Final element of the token |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 8 | Signed two's-complement quantized code |
| out_first | output | 1 | First code of a token |
| out_last | output | 1 | Final code of a token |
| out_scale | output | DATA_W | Unsigned per-token largest magnitude |

## Verification
Two events can share a clock edge. The final code of one token may still be held in the output register under backpressure while the first word of the next token is being written into the buffer and starts a new running maximum. The bench provokes this by sending tokens back to back while holding `out_ready` low at random about a quarter of the time. It then judges every code, flag and scale against a per-token reference, so a leak of the new maximum or a lost, duplicated or reordered word shows up as a mismatch. Directed tokens cover rounding ties, all-equal, single-outlier, negative-only, zero and full-scale cases.

// File: rtl/qz_pkg.sv
package qz_pkg;
    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_DIV  = 2'd1,
        ST_EMIT = 2'd2
    } qz_state_e;

    localparam int QZ_CODE_W = 8;
    localparam int QZ_PEAK   = 127;
endpackage

// File: rtl/qz_token_buf.sv
module qz_token_buf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/qz_recip.sv
// Serial restoring divider producing ceil(2^FB / divisor).
module qz_recip #(
    parameter int DATA_W = 16,
    localparam int DB    = DATA_W + 1,
    localparam int NB    = DATA_W + 7,
    localparam int FB    = NB + DB,
    localparam int QW    = FB + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DB-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [QW-1:0] quot
);
    localparam int CW = $clog2(QW + 1);
    localparam int PW = QW + DB;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [DB-1:0] rem;
        logic [QW-1:0] dvd;
        logic [QW-1:0] quot;
        logic [DB-1:0] dsr;
    } div_t;

    div_t q, d;
    logic [DB:0] trial;
    logic        qbit;

    always_comb begin
        d     = q;
        d.done = 1'b0;
        trial = {q.rem, q.dvd[QW-1]};
        qbit  = 1'b0;
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = CW'(QW);
            d.rem  = '0;
            d.dvd  = (QW'(1) << FB) + QW'(divisor) - QW'(1);
            d.quot = '0;
            d.dsr  = divisor;
        end else if (q.busy) begin
            d.dvd = q.dvd << 1;
            if (trial >= {1'b0, q.dsr}) begin
                d.rem = DB'(trial - {1'b0, q.dsr});
                qbit  = 1'b1;
            end else begin
                d.rem = trial[DB-1:0];
            end
            d.quot = {q.quot[QW-2:0], qbit};
            d.cnt  = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = q.busy;
    assign done = q.done;
    assign quot = q.quot;

    // R2: the reciprocal is the exact ceiling of 2^FB / divisor
    p_recip_ceil_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> ((PW'(q.quot) * PW'(q.dsr)) >= (PW'(1) << FB)) &&
                   (((PW'(q.quot) - PW'(1)) * PW'(q.dsr)) < (PW'(1) << FB)));

    // R2: completion is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
endmodule

// File: rtl/qz_scaler.sv
// Maps one element to its code: sign(x)*floor((254|x| + m) / 2m), clipped.
module qz_scaler #(
    parameter int DATA_W = 16,
    localparam int DB    = DATA_W + 1,
    localparam int NB    = DATA_W + 7,
    localparam int FB    = NB + DB,
    localparam int QW    = FB + 1
) (
    input  logic [DATA_W-1:0] elem,
    input  logic [DATA_W-1:0] amax,
    input  logic [QW-1:0]     recip,
    output logic [7:0]        code
);
    localparam int PW = NB + QW;

    logic [DATA_W-1:0] mag;
    logic [NB-1:0]     num;
    logic [PW-1:0]     prod;
    logic [PW-1:0]     qwide;
    logic [6:0]        qmag;
    logic [7:0]        qpos;

    always_comb begin
        mag   = elem[DATA_W-1] ? (~elem + 1'b1) : elem;
        num   = (NB'(mag) << 8) - (NB'(mag) << 1) + NB'(amax);
        prod  = PW'(num) * PW'(recip);
        qwide = prod >> FB;
        qmag  = (qwide > PW'(qz_pkg::QZ_PEAK)) ? 7'(qz_pkg::QZ_PEAK) : qwide[6:0];
        qpos  = {1'b0, qmag};
        if (amax == '0) begin
            code = '0;
        end else if (elem[DATA_W-1]) begin
            code = ~qpos + 8'd1;
        end else begin
            code = qpos;
        end
    end
endmodule

// File: rtl/qz_token_quant.sv
module qz_token_quant #(
    parameter int DATA_W  = 16,
    parameter int MAX_LEN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_first,
    output logic              out_last,
    output logic [DATA_W-1:0] out_scale
);
    import qz_pkg::*;

    localparam int AW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam int DB = DATA_W + 1;
    localparam int NB = DATA_W + 7;
    localparam int FB = NB + DB;
    localparam int QW = FB + 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(MAX_LEN - 1);

    typedef struct packed {
        qz_state_e             st;
        logic [AW-1:0]         wr_idx;
        logic [AW-1:0]         rd_idx;
        logic [AW-1:0]         len_m1;
        logic [DATA_W-1:0]     amax;
        logic [QW-1:0]         recip;
        logic                  first_pend;
        logic                  div_start;
        logic                  ov;
        logic [QZ_CODE_W-1:0]  od;
        logic                  of;
        logic                  ol;
        logic [DATA_W-1:0]     oscale;
    } regs_t;

    regs_t q, d;

    logic              buf_we;
    logic [DATA_W-1:0] buf_rd;
    logic [DATA_W-1:0] in_mag;
    logic [DATA_W-1:0] run_max;
    logic              slot_free;
    logic [7:0]        scaled;
    logic              div_busy;
    logic              div_done;
    logic [QW-1:0]     div_quot;

    qz_token_buf #(.DATA_W(DATA_W), .DEPTH(MAX_LEN)) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_addr (q.wr_idx),
        .wr_data (in_data),
        .rd_addr (q.rd_idx),
        .rd_data (buf_rd)
    );

    qz_recip #(.DATA_W(DATA_W)) u_recip (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (q.div_start),
        .divisor ({q.amax, 1'b0}),
        .busy    (div_busy),
        .done    (div_done),
        .quot    (div_quot)
    );

    qz_scaler #(.DATA_W(DATA_W)) u_scaler (
        .elem  (buf_rd),
        .amax  (q.amax),
        .recip (q.recip),
        .code  (scaled)
    );

    always_comb begin
        d           = q;
        d.div_start = 1'b0;
        buf_we      = 1'b0;
        in_mag      = in_data[DATA_W-1] ? (~in_data + 1'b1) : in_data;
        if (q.wr_idx == '0) begin
            run_max = in_mag;
        end else begin
            run_max = (in_mag > q.amax) ? in_mag : q.amax;
        end
        slot_free = !q.ov || out_ready;
        if (q.ov && out_ready) begin
            d.ov = 1'b0;
        end
        unique case (q.st)
            ST_FILL: begin
                if (in_valid) begin
                    buf_we = 1'b1;
                    d.amax = run_max;
                    if (in_last || (q.wr_idx == LAST_IDX)) begin
                        d.len_m1     = q.wr_idx;
                        d.wr_idx     = '0;
                        d.rd_idx     = '0;
                        d.first_pend = 1'b1;
                        if (run_max == '0) begin
                            d.st = ST_EMIT;
                        end else begin
                            d.st        = ST_DIV;
                            d.div_start = 1'b1;
                        end
                    end else begin
                        d.wr_idx = q.wr_idx + 1'b1;
                    end
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    d.recip = div_quot;
                    d.st    = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (slot_free) begin
                    d.ov         = 1'b1;
                    d.od         = scaled;
                    d.of         = q.first_pend;
                    d.first_pend = 1'b0;
                    d.ol         = (q.rd_idx == q.len_m1);
                    d.oscale     = q.amax;
                    if (q.rd_idx == q.len_m1) begin
                        d.st = ST_FILL;
                    end else begin
                        d.rd_idx = q.rd_idx + 1'b1;
                    end
                end
            end
            default: d.st = ST_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready  = (q.st == ST_FILL);
    assign out_valid = q.ov;
    assign out_data  = q.od;
    assign out_first = q.of;
    assign out_last  = q.ol;
    assign out_scale = q.oscale;

    // R9: a stalled output word keeps every field
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) &&
            $stable(out_first) && $stable(out_last) && $stable(out_scale));

    // R3: the most negative 8-bit code never leaves the block
    p_no_min_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data != 8'h80);

    // R5: a zero scale comes only with zero codes
    p_zero_token_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_scale == '0) |-> out_data == 8'h00);

    // R7: after a consumed final word the next word opens a token
    p_first_follows_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid || out_first);

    // R2: the divider is only started when idle
    p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.div_start |-> !div_busy);
endmodule

// File: tb/qz_token_quant_bench.sv
module qz_token_quant_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int MAX_LEN    = 1024;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic              in_ready;
    logic [DATA_W-1:0] in_data;
    logic              in_last;
    logic              out_valid;
    logic              out_ready;
    logic [7:0]        out_data;
    logic              out_first;
    logic              out_last;
    logic [DATA_W-1:0] out_scale;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    int    tok[$];
    int    exp_d[$];
    int    exp_s[$];
    bit    exp_f[$];
    bit    exp_l[$];
    bit    exp_pk[$];
    string exp_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    qz_token_quant #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) u_qz_token_quant (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_first (out_first),
        .out_last  (out_last),
        .out_scale (out_scale)
    );

    function automatic int ref_code(int x, int m);
        int mag;
        int r;
        if (m == 0) return 0;
        mag = (x < 0) ? -x : x;
        r = (254 * mag + m) / (2 * m);
        if (r > 127) r = 127;
        return (x < 0) ? -r : r;
    endfunction

    function automatic int rand_val();
        int sh;
        int v;
        sh = int'($urandom % 16);
        v  = int'($urandom % (32'd1 << sh));
        if ($urandom % 2 == 1) v = -v;
        if ($urandom % 97 == 0) v = -32768;
        return v;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Sends the words held in tok; forced=1 leaves in_last low throughout.
    task automatic send_token(bit forced, string tag);
        int m;
        int n;
        m = 0;
        n = tok.size();
        foreach (tok[i]) begin
            int a;
            a = (tok[i] < 0) ? -tok[i] : tok[i];
            if (a > m) m = a;
        end
        for (int i = 0; i < n; i++) begin
            int a;
            a = (tok[i] < 0) ? -tok[i] : tok[i];
            exp_d.push_back(ref_code(tok[i], m));
            exp_s.push_back(m);
            exp_f.push_back(i == 0);
            exp_l.push_back(i == n - 1);
            exp_pk.push_back((m != 0) && (a == m));
            if (m == 0) exp_tag.push_back("R5");
            else if (tok[i] == 0) exp_tag.push_back("R4");
            else exp_tag.push_back(tag);
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ($urandom % 6 == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = DATA_W'(tok[i]);
            in_last  = forced ? 1'b0 : (i == n - 1);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(in_ready == 1'b0, "R10", "in_ready after token close", int'(in_ready), 0);
    endtask

    // Output monitor with random backpressure
    initial begin
        bit         hold;
        bit         r;
        logic [7:0] h_d;
        logic       h_f;
        logic       h_l;
        logic [DATA_W-1:0] h_s;
        hold = 0;
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n !== 1'b1) begin
                out_ready = 1'b0;
                hold = 0;
            end else begin
                if (hold) begin
                    check(out_valid && out_data == h_d && out_first == h_f &&
                          out_last == h_l && out_scale == h_s,
                          "R9", "stalled word changed", int'(out_data), int'(h_d));
                end
                r = ($urandom % 4) != 0;
                out_ready = r;
                hold = out_valid && !r;
                h_d = out_data;
                h_f = out_first;
                h_l = out_last;
                h_s = out_scale;
                if (out_valid && r) begin
                    if (exp_d.size() == 0) begin
                        check(1'b0, "R7", "unexpected output word", int'($signed(out_data)), 0);
                    end else begin
                        int    ed;
                        int    es;
                        bit    ef;
                        bit    el;
                        bit    ep;
                        string et;
                        int    got;
                        ed = exp_d.pop_front();
                        es = exp_s.pop_front();
                        ef = exp_f.pop_front();
                        el = exp_l.pop_front();
                        ep = exp_pk.pop_front();
                        et = exp_tag.pop_front();
                        got = int'($signed(out_data));
                        check(got == ed, et, "code", got, ed);
                        check(out_data != 8'h80, "R3", "code -128 produced", got, -127);
                        if (ep) check(got == 127 || got == -127, "R3", "peak code", got, ed);
                        check(out_first == ef, "R7", "out_first", int'(out_first), int'(ef));
                        check(out_last == el, "R7", "out_last", int'(out_last), int'(el));
                        if (ef) begin
                            check(int'(out_scale) == es, (es == 0) ? "R5" : "R1",
                                  "scale", int'(out_scale), es);
                        end
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", exp_d.size(), 0);
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0F17));
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        in_last  = 1'b0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R10", "in_ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // rounding ties and zero element
        tok = '{2, 1, -1, 0};
        send_token(0, "R2");
        // all-equal, positive and negative
        tok.delete();
        for (int i = 0; i < 8; i++) tok.push_back(300);
        send_token(0, "R2");
        tok.delete();
        for (int i = 0; i < 6; i++) tok.push_back(-4097);
        send_token(0, "R2");
        // single outlier
        tok.delete();
        for (int i = 0; i < 20; i++) tok.push_back(int'($urandom % 17) - 8);
        tok[11] = -20000;
        send_token(0, "R2");
        // negative only
        tok.delete();
        for (int i = 0; i < 16; i++) tok.push_back(-1 - int'($urandom % 30000));
        send_token(0, "R2");
        // zero vector
        tok = '{0, 0, 0, 0, 0};
        send_token(0, "R5");
        // one-word full-scale token
        tok = '{-32768};
        send_token(0, "R1");
        // large then small
        tok = '{32767, -5, 12};
        send_token(0, "R2");
        tok = '{5, -3, 1, 2};
        send_token(0, "R6");
        // buffer-full close without marker
        tok.delete();
        for (int i = 0; i < MAX_LEN; i++) tok.push_back(rand_val());
        send_token(1, "R8");
        tok = '{7, -2};
        send_token(0, "R6");
        // random tokens
        for (int t = 0; t < 40; t++) begin
            int len;
            int mode;
            len  = 1 + int'($urandom % 64);
            mode = int'($urandom % 4);
            tok.delete();
            for (int i = 0; i < len; i++) begin
                case (mode)
                    0: tok.push_back(rand_val());
                    1: tok.push_back(-int'($urandom % 32769));
                    2: tok.push_back(int'($urandom % 9) - 4);
                    default: tok.push_back((i % 5 == 0) ? 0 : rand_val());
                endcase
            end
            send_token(0, "R2");
        end

        while (exp_d.size() > 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R7", "no extra words", int'(out_valid), 0);
        check(in_ready == 1'b1, "R10", "ready when drained", int'(in_ready), 1);
        summary();
    end
endmodule